// File: doc/BRIEF.md
# Instruction Cycle Cost Accumulator

This block keeps the clock-cycle account for an 8-bit processor that runs the classic 151-opcode accumulator instruction set. Each retired instruction is presented as one opcode byte with a one-cycle valid strobe and a flag that says whether a conditional branch was taken. The block classifies the opcode into an addressing mode and an operation class, forms the cycle cost of that instruction, and adds the cost to a free-running total.

The cost is assembled from independent parts: a two-cycle floor, an addressing surcharge, one extra cycle for indexed stores and indexed read-modify-write accesses, and an operation surcharge (stack traffic, subroutine linkage, memory-target shifts and counts, taken branches, and a one-cycle rebate for jumps). Page-crossing penalties are not modelled, so an indexed load costs the same whether or not its index carries into the high address byte. Opcodes outside the supported set raise a one-cycle flag and leave the account untouched.

Top module: `cycle_acct_unit`

## Requirements
- R1: While rst_n is low, cycle_total, last_cost and illegal_op are all zero.
- R2: Implied, accumulator and immediate forms cost 2 cycles (for example 0xEA, 0xA9, 0x0A, 0x18).
- R3: Loads pay the addressing surcharge only: zero page 3, zero page indexed 4, absolute 4, absolute indexed 4, (zp,X) 6, (zp),Y 5 cycles.
- R4: Stores through absolute indexed (0x9D, 0x99) cost 5 and through (zp),Y (0x91) cost 6; zero-page stores (0x85) cost 3 and 0x96 costs 4.
- R5: Memory-target shift, rotate, increment and decrement cost 5 for zero page, 6 for zero page indexed and absolute, 7 for absolute indexed.
- R6: Absolute jump 0x4C costs 3, indirect jump 0x6C costs 5, subroutine call 0x20 costs 6.
- R7: Subroutine return 0x60 and interrupt return 0x40 cost 6; software break 0x00 costs 7.
- R8: Pushes 0x48 and 0x08 cost 3; pulls 0x68 and 0x28 cost 4.
- R9: Conditional branches (opcodes with low five bits 0x10) cost 3 when branch_taken is high and 2 when it is low; branch_taken has no effect on any other opcode.
- R10: In the cycle after a strobe of a supported opcode, cycle_total grows by that opcode's cost, modulo 2^TOTAL_W; with no such strobe it does not change, and strobes in consecutive cycles are each counted.
- R11: A strobe of an unsupported opcode (every opcode with low two bits 11, and 0x02, 0x89, 0x9E, 0x80, 0x0C, 0x44 among others) sets illegal_op for the following cycle only and changes neither cycle_total nor last_cost.
- R12: last_cost shows the cost of the most recent supported instruction and holds it until the next supported strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle strobe: an instruction retired |
| opcode | input | 8 | Opcode byte of the retired instruction |
| branch_taken | input | 1 | High when a conditional branch was taken |
| last_cost | output | COST_W | Cycle cost of the latest supported instruction |
| cycle_total | output | TOTAL_W | Running cycle total |
| illegal_op | output | 1 | One-cycle pulse after an unsupported opcode |

## Verification
The bench sweeps all 256 opcode values with both branch_taken levels against its own cost model, so a decoder that mislabels a single column of the opcode map shows up as a wrong cost or a spurious illegal pulse. The sharpest corners are the indexed store and read-modify-write extra cycle (a design that charges it to indexed loads, or omits it, is off by one), the jump rebate (without it the jumps read 4 and 6), and branch_taken leaking into non-branch opcodes. It also strobes instructions in back-to-back cycles, follows an unsupported opcode with idle cycles to see that the total and the last cost are frozen, and runs a four-bit-total instance alongside to catch an adder that saturates instead of wrapping.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  // Addressing shape of an instruction, as far as cycle cost cares
  typedef enum logic [2:0] {
    AM_NONE,    // implied, accumulator, immediate, relative
    AM_ZP,
    AM_ZPIDX,
    AM_ABS,
    AM_ABSIDX,
    AM_IND,
    AM_INDX,
    AM_INDY
  } amode_e;

  // Operation class, as far as cycle cost cares
  typedef enum logic [3:0] {
    OC_PLAIN,
    OC_STORE,
    OC_RMW,
    OC_JMP,
    OC_JSR,
    OC_RET,
    OC_BRK,
    OC_PUSH,
    OC_PULL,
    OC_BRANCH
  } oclass_e;

  typedef struct packed {
    logic    legal;
    amode_e  mode;
    oclass_e cls;
  } dec_t;

endpackage

// File: rtl/opc_decode.sv
module opc_decode
  import cyc_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  logic [1:0] grp;
  logic [2:0] row;
  logic [2:0] col;
  logic       mem_col;
  logic       rmw_row;

  assign grp     = opcode[1:0];
  assign row     = opcode[7:5];
  assign col     = opcode[4:2];
  assign mem_col = col[0];                  // columns 1,3,5,7 touch memory
  assign rmw_row = (row != 3'd4) && (row != 3'd5);

  always_comb begin
    dec = '{legal: 1'b0, mode: AM_NONE, cls: OC_PLAIN};
    case (grp)
      // arithmetic / logic / load / store accumulator group
      2'b01: begin
        dec.legal = !((row == 3'd4) && (col == 3'd2));
        dec.cls   = (row == 3'd4) ? OC_STORE : OC_PLAIN;
        case (col)
          3'd0:    dec.mode = AM_INDX;
          3'd1:    dec.mode = AM_ZP;
          3'd2:    dec.mode = AM_NONE;
          3'd3:    dec.mode = AM_ABS;
          3'd4:    dec.mode = AM_INDY;
          3'd5:    dec.mode = AM_ZPIDX;
          default: dec.mode = AM_ABSIDX;
        endcase
      end
      // shift / rotate / count / X-register group
      2'b10: begin
        case (col)
          3'd0:    dec.legal = (row == 3'd5);
          3'd4:    dec.legal = 1'b0;
          3'd6:    dec.legal = !rmw_row;
          3'd7:    dec.legal = (row != 3'd4);
          default: dec.legal = 1'b1;
        endcase
        case (col)
          3'd1:    dec.mode = AM_ZP;
          3'd3:    dec.mode = AM_ABS;
          3'd5:    dec.mode = AM_ZPIDX;
          3'd7:    dec.mode = AM_ABSIDX;
          default: dec.mode = AM_NONE;
        endcase
        if (mem_col && rmw_row)           dec.cls = OC_RMW;
        else if (mem_col && row == 3'd4)  dec.cls = OC_STORE;
        else                              dec.cls = OC_PLAIN;
      end
      // control / Y-register group
      2'b00: begin
        case (col)
          3'd0: begin
            dec.legal = (row != 3'd4);
            case (row)
              3'd0:       dec.cls = OC_BRK;
              3'd1: begin dec.cls = OC_JSR; dec.mode = AM_ABS; end
              3'd2, 3'd3: dec.cls = OC_RET;
              default:    dec.cls = OC_PLAIN;
            endcase
          end
          3'd1: begin
            dec.legal = (row == 3'd1) || (row >= 3'd4);
            dec.mode  = AM_ZP;
            dec.cls   = (row == 3'd4) ? OC_STORE : OC_PLAIN;
          end
          3'd2: begin
            dec.legal = 1'b1;
            case (row)
              3'd0, 3'd2: dec.cls = OC_PUSH;
              3'd1, 3'd3: dec.cls = OC_PULL;
              default:    dec.cls = OC_PLAIN;
            endcase
          end
          3'd3: begin
            dec.legal = (row != 3'd0);
            dec.mode  = (row == 3'd3) ? AM_IND : AM_ABS;
            case (row)
              3'd2, 3'd3: dec.cls = OC_JMP;
              3'd4:       dec.cls = OC_STORE;
              default:    dec.cls = OC_PLAIN;
            endcase
          end
          3'd4: begin
            dec.legal = 1'b1;
            dec.cls   = OC_BRANCH;
          end
          3'd5: begin
            dec.legal = (row == 3'd4) || (row == 3'd5);
            dec.mode  = AM_ZPIDX;
            dec.cls   = (row == 3'd4) ? OC_STORE : OC_PLAIN;
          end
          3'd6:    dec.legal = 1'b1;
          default: begin
            dec.legal = (row == 3'd5);
            dec.mode  = AM_ABSIDX;
          end
        endcase
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/cost_calc.sv
module cost_calc
  import cyc_pkg::*;
#(
  parameter int COST_W = 3
) (
  input  amode_e              mode,
  input  oclass_e             cls,
  input  logic                taken,
  output logic [COST_W-1:0]   cost
);

  localparam logic [COST_W-1:0] BASE = COST_W'(2);

  logic [COST_W-1:0] mode_add;
  logic [COST_W-1:0] op_add;
  logic              idx_extra;
  logic              jmp_rebate;

  always_comb begin
    case (mode)
      AM_ZP:             mode_add = COST_W'(1);
      AM_ZPIDX, AM_ABS,
      AM_ABSIDX:         mode_add = COST_W'(2);
      AM_INDY:           mode_add = COST_W'(3);
      AM_IND, AM_INDX:   mode_add = COST_W'(4);
      default:           mode_add = '0;
    endcase
  end

  always_comb begin
    case (cls)
      OC_RMW, OC_JSR, OC_PULL: op_add = COST_W'(2);
      OC_RET:                  op_add = COST_W'(4);
      OC_BRK:                  op_add = COST_W'(5);
      OC_PUSH:                 op_add = COST_W'(1);
      OC_BRANCH:               op_add = taken ? COST_W'(1) : '0;
      default:                 op_add = '0;
    endcase
  end

  assign idx_extra  = ((mode == AM_ABSIDX) || (mode == AM_INDY)) &&
                      ((cls == OC_STORE) || (cls == OC_RMW));
  assign jmp_rebate = (cls == OC_JMP);

  assign cost = BASE + mode_add + op_add + COST_W'(idx_extra) - COST_W'(jmp_rebate);

endmodule

// File: rtl/cyc_accum.sv
module cyc_accum #(
  parameter int TOTAL_W = 32,
  parameter int COST_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               legal,
  input  logic [COST_W-1:0]  cost,
  output logic [TOTAL_W-1:0] total,
  output logic [COST_W-1:0]  last_cost,
  output logic               illegal
);

  logic [TOTAL_W-1:0] total_q, total_d;
  logic [COST_W-1:0]  cost_q;
  logic               ill_q, ill_d;
  logic               upd_en;

  // next state
  always_comb begin
    upd_en  = strobe && legal;
    total_d = total_q + TOTAL_W'(cost);
    ill_d   = strobe && !legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      cost_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      if (upd_en) begin
        total_q <= total_d;
        cost_q  <= cost;
      end
      ill_q <= ill_d;
    end
  end

  assign total     = total_q;
  assign last_cost = cost_q;
  assign illegal   = ill_q;

  // R10
  total_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && legal) |=> (total_q == $past(total_q) + TOTAL_W'($past(cost))));

  // R10
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && legal) |=> $stable(total_q));

  // R11
  ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !ill_q);

  // R11
  ill_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !legal) |=> ill_q);

  // R12
  cost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && legal) |=> $stable(cost_q));

endmodule

// File: rtl/cycle_acct_unit.sv
module cycle_acct_unit
  import cyc_pkg::*;
#(
  parameter int TOTAL_W = 32,
  parameter int COST_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [7:0]         opcode,
  input  logic               branch_taken,
  output logic [COST_W-1:0]  last_cost,
  output logic [TOTAL_W-1:0] cycle_total,
  output logic               illegal_op
);

  dec_t              dec;
  logic [COST_W-1:0] cost;

  opc_decode i_decode (
    .opcode (opcode),
    .dec    (dec)
  );

  cost_calc #(.COST_W(COST_W)) i_cost (
    .mode  (dec.mode),
    .cls   (dec.cls),
    .taken (branch_taken),
    .cost  (cost)
  );

  cyc_accum #(.TOTAL_W(TOTAL_W), .COST_W(COST_W)) i_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (instr_valid),
    .legal     (dec.legal),
    .cost      (cost),
    .total     (cycle_total),
    .last_cost (last_cost),
    .illegal   (illegal_op)
  );

  // R9
  branch_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.legal && dec.cls == OC_BRANCH) |->
      (cost == (branch_taken ? COST_W'(3) : COST_W'(2))));

  // R2
  cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec.legal |-> (cost >= COST_W'(2)));

  // R6
  jmp_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.legal && dec.cls == OC_JMP) |-> (cost == COST_W'(3) || cost == COST_W'(5)));

endmodule

// File: tb/test_cycle_acct_unit.sv
`timescale 1ns/1ps
module test_cycle_acct_unit;

  localparam int TW = 32;
  localparam int CW = 3;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic          branch_taken = 1'b0;
  logic [7:0]    opcode = 8'h00;
  logic [CW-1:0] last_cost, n_last_cost;
  logic [TW-1:0] cycle_total;
  logic [NW-1:0] n_total;
  logic          illegal_op, n_illegal;

  int            checks = 0;
  int            fails  = 0;
  logic [31:0]   exp_total = 0;
  int            exp_cost  = 0;
  logic          exp_ill   = 1'b0;

  always #2 clk = ~clk;

  cycle_acct_unit #(.TOTAL_W(TW), .COST_W(CW)) i_cycle_acct_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .branch_taken(branch_taken), .last_cost(last_cost),
    .cycle_total(cycle_total), .illegal_op(illegal_op)
  );

  // narrow-total copy for wrap checking (R10)
  cycle_acct_unit #(.TOTAL_W(NW), .COST_W(CW)) i_narrow (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .branch_taken(branch_taken), .last_cost(n_last_cost),
    .cycle_total(n_total), .illegal_op(n_illegal)
  );

  // Independent cost model, organised by the low five opcode bits; 0 = unsupported
  function automatic int model(input logic [7:0] op, input logic tk);
    logic [2:0] hi;
    hi = op[7:5];
    case (op[4:0])
      5'h01: return 6;
      5'h05: return 3;
      5'h09: return (op == 8'h89) ? 0 : 2;
      5'h0D: return 4;
      5'h11: return (op == 8'h91) ? 6 : 5;
      5'h15: return 4;
      5'h19, 5'h1D: return (op == 8'h99 || op == 8'h9D) ? 5 : 4;
      5'h02: return (op == 8'hA2) ? 2 : 0;
      5'h06: return (hi == 3'd4 || hi == 3'd5) ? 3 : 5;
      5'h0A: return 2;
      5'h0E, 5'h16: return (hi == 3'd4 || hi == 3'd5) ? 4 : 6;
      5'h1A: return (op == 8'h9A || op == 8'hBA) ? 2 : 0;
      5'h1E: return (op == 8'h9E) ? 0 : ((op == 8'hBE) ? 4 : 7);
      5'h00: begin
        if (op == 8'h00) return 7;
        if (op == 8'h20 || op == 8'h40 || op == 8'h60) return 6;
        if (op == 8'h80) return 0;
        return 2;
      end
      5'h04: return (hi == 3'd0 || hi == 3'd2 || hi == 3'd3) ? 0 : 3;
      5'h08: begin
        if (op == 8'h08 || op == 8'h48) return 3;
        if (op == 8'h28 || op == 8'h68) return 4;
        return 2;
      end
      5'h0C: begin
        if (op == 8'h0C) return 0;
        if (op == 8'h4C) return 3;
        if (op == 8'h6C) return 5;
        return 4;
      end
      5'h10: return tk ? 3 : 2;
      5'h14: return (op == 8'h94 || op == 8'hB4) ? 4 : 0;
      5'h18: return 2;
      5'h1C: return (op == 8'hBC) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // outputs against the bench's own bookkeeping
  task automatic verify(input string tag);
    chk(tag, "last_cost",   32'(last_cost),  32'(exp_cost));
    chk(tag, "illegal_op",  32'(illegal_op), 32'(exp_ill));
    chk(tag, "cycle_total", cycle_total,     exp_total);
    chk(tag, "narrow_total", 32'(n_total),   32'(exp_total[NW-1:0]));
  endtask

  task automatic book(input logic [7:0] op, input logic tk);
    int m;
    m = model(op, tk);
    exp_ill = (m == 0);
    if (m != 0) begin
      exp_cost  = m;
      exp_total = exp_total + 32'(m);
    end
  endtask

  task automatic run_one(input logic [7:0] op, input logic tk, input string tag);
    @(negedge clk);
    opcode = op; branch_taken = tk; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    book(op, tk);
    verify(tag);
  endtask

  task automatic spot(input logic [7:0] op, input logic tk, input int lit, input string tag);
    run_one(op, tk, tag);
    if (lit == 0) chk(tag, $sformatf("unsupported %02h flag", op), 32'(illegal_op), 32'd1);
    else          chk(tag, $sformatf("cost of %02h", op), 32'(last_cost), 32'(lit));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "total in reset", cycle_total, 32'd0);
    chk("R1", "cost in reset",  32'(last_cost), 32'd0);
    chk("R1", "flag in reset",  32'(illegal_op), 32'd0);
    rst_n = 1'b1;
    exp_total = 0; exp_cost = 0; exp_ill = 1'b0;
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    exp_ill = 1'b0;
    verify("R10");
  endtask

  task automatic t_costs();
    spot(8'hEA, 1'b0, 2, "R2"); spot(8'hA9, 1'b0, 2, "R2");
    spot(8'h0A, 1'b0, 2, "R2"); spot(8'h18, 1'b0, 2, "R2");
    spot(8'hA5, 1'b0, 3, "R3"); spot(8'hB5, 1'b0, 4, "R3");
    spot(8'hAD, 1'b0, 4, "R3"); spot(8'hA1, 1'b0, 6, "R3");
    spot(8'hB1, 1'b0, 5, "R3"); spot(8'hBD, 1'b0, 4, "R3");
    spot(8'hB9, 1'b0, 4, "R3"); spot(8'hB6, 1'b0, 4, "R3");
    spot(8'h9D, 1'b0, 5, "R4"); spot(8'h99, 1'b0, 5, "R4");
    spot(8'h91, 1'b0, 6, "R4"); spot(8'h96, 1'b0, 4, "R4");
    spot(8'h85, 1'b0, 3, "R4");
    spot(8'h06, 1'b0, 5, "R5"); spot(8'h16, 1'b0, 6, "R5");
    spot(8'h0E, 1'b0, 6, "R5"); spot(8'h1E, 1'b0, 7, "R5");
    spot(8'hE6, 1'b0, 5, "R5"); spot(8'hDE, 1'b0, 7, "R5");
    spot(8'h4C, 1'b0, 3, "R6"); spot(8'h6C, 1'b0, 5, "R6");
    spot(8'h20, 1'b0, 6, "R6");
    spot(8'h60, 1'b0, 6, "R7"); spot(8'h40, 1'b0, 6, "R7");
    spot(8'h00, 1'b0, 7, "R7");
    spot(8'h48, 1'b0, 3, "R8"); spot(8'h08, 1'b0, 3, "R8");
    spot(8'h68, 1'b0, 4, "R8"); spot(8'h28, 1'b0, 4, "R8");
    spot(8'hD0, 1'b1, 3, "R9"); spot(8'hD0, 1'b0, 2, "R9");
    spot(8'h10, 1'b1, 3, "R9"); spot(8'hA9, 1'b1, 2, "R9");
    spot(8'h1E, 1'b1, 7, "R9");
  endtask

  task automatic t_illegal();
    spot(8'h02, 1'b0, 0, "R11"); spot(8'h89, 1'b0, 0, "R11");
    spot(8'h9E, 1'b1, 0, "R11"); spot(8'hFF, 1'b0, 0, "R11");
    @(negedge clk);
    exp_ill = 1'b0;
    verify("R11");
  endtask

  task automatic t_hold();
    spot(8'hA5, 1'b0, 3, "R12");
    spot(8'h80, 1'b0, 0, "R12");
    repeat (3) @(negedge clk);
    exp_ill = 1'b0;
    chk("R12", "cost held", 32'(last_cost), 32'd3);
    verify("R12");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    opcode = 8'h00; branch_taken = 1'b0; instr_valid = 1'b1;
    @(negedge clk);
    book(8'h00, 1'b0);
    verify("R10");
    opcode = 8'h20;
    @(negedge clk);
    book(8'h20, 1'b0);
    verify("R10");
    opcode = 8'h0C;
    @(negedge clk);
    instr_valid = 1'b0;
    book(8'h0C, 1'b0);
    verify("R10");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 5; i++) run_one(8'h00, 1'b0, "R10");
    chk("R10", "narrow wrap", 32'(n_total), 32'(exp_total[NW-1:0]));
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 256; op++) begin
      for (int tk = 0; tk < 2; tk++) begin
        int m;
        m = model(8'(op), tk[0]);
        run_one(8'(op), tk[0], (m == 0) ? "R11" : ((op[4:0] == 5'h10) ? "R9" : "R3"));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_costs();
    t_illegal();
    t_hold();
    t_back_to_back();
    t_wrap();
    t_sweep();
    t_idle();
    finish_run();
  end

endmodule